// File: doc/BRIEF.md
# Register Stack with Full and Empty Flags

This block is a last-in-first-out store built from registers. It holds 64 words. A single pointer selects the slot that is on top, and no separate occupancy count exists. A push advances the pointer and then writes the incoming word into the slot the pointer now selects. A pop copies the word at the pointer into an output data register and then moves the pointer back by one. Because of this order, slot 0 is filled last, by the 64th push.

The full and empty flags come from the pointer wrapping. When a push carries the pointer from its highest value around to zero, the stack is full. When a pop brings the pointer down to zero, the stack is empty. A push while full or a pop while empty is refused: the pointer, the flags and the stored words stay as they are, and a one-cycle error pulse is raised. A request that asserts push and pop together does nothing.

Top module: `lifo_regstack`

## Requirements
- R1: After a synchronous active-high reset, the pointer is 0, empty is 1, full is 0, the error output is 0 and the read data register is 0.
- R2: A push accepted while not full advances the pointer by one (modulo 64) one clock after the request and clears empty.
- R3: The 64th push accepted after empty moves the pointer from 63 to 0 and sets full. Earlier pushes leave full at 0.
- R4: A push while full is ignored. The pointer, the flags and the stored words are unchanged, and the error output is 1 for the following cycle.
- R5: A pop returns the most recently pushed word that is still on the stack, in strict last-in-first-out order. The word appears on the read data output one clock after the request.
- R6: A pop accepted while not empty moves the pointer back by one and clears full. The pop that brings the pointer to 0 sets empty.
- R7: A pop while empty is ignored. The pointer, the flags and the read data output are unchanged, and the error output is 1 for the following cycle.
- R8: When push and pop are asserted in the same cycle, neither takes effect. The pointer, the flags and the read data stay the same, and no error is raised.
- R9: The error output is a single-cycle pulse per refused request, and it is 0 after every accepted or idle cycle.
- R10: The read data output changes only on an accepted pop. It holds its value across idle cycles and pushes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| push_i | input | 1 | Push request for this cycle |
| pop_i | input | 1 | Pop request for this cycle |
| wdata_i | input | WIDTH (8) | Word to push |
| rdata_o | output | WIDTH (8) | Data register holding the last popped word |
| sp_o | output | log2(DEPTH) (6) | Current stack pointer |
| full_o | output | 1 | Stack holds DEPTH words |
| empty_o | output | 1 | Stack holds no words |
| err_o | output | 1 | One-cycle pulse after a refused push or pop |

## Verification
A pointer that steps wrongly shows up on the pointer output one clock after the request. It also shows up later on the read data output, as a word that is out of order or stale, when the stack is drained. A flag that is set late or not at all is exposed at the wrap: the 65th push of a full fill must raise the error on the next cycle and leave the pointer at 0. A corrupted slot, or a write made by a refused push, only shows up when that slot is popped. For this reason the bench empties a completely filled stack and compares every word against the order in which the words were pushed.

// File: rtl/lifo_pkg.sv
package lifo_pkg;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_PUSH = 2'd1,
        OP_POP  = 2'd2,
        OP_BAD  = 2'd3
    } lifo_op_e;

    // Resolve the raw request pins against the current flags.
    function automatic lifo_op_e classify(input logic push,
                                          input logic pop,
                                          input logic full,
                                          input logic empty);
        lifo_op_e op;
        op = OP_IDLE;
        if (push && !pop) begin
            op = full ? OP_BAD : OP_PUSH;
        end else if (pop && !push) begin
            op = empty ? OP_BAD : OP_POP;
        end
        return op;
    endfunction

endpackage

// File: rtl/lifo_ptrctl.sv
module lifo_ptrctl
    import lifo_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic          pop,
    output logic [AW-1:0] sp,
    output logic [AW-1:0] wr_addr,
    output logic          wr_en,
    output logic          rd_en,
    output logic          full,
    output logic          empty,
    output logic          err
);

    lifo_op_e      op;
    logic [AW-1:0] sp_up;
    logic [AW-1:0] sp_dn;

    always_comb begin
        op    = classify(push, pop, full, empty);
        sp_up = sp + AW'(1);
        sp_dn = sp - AW'(1);
    end

    assign wr_addr = sp_up;
    assign wr_en   = (op == OP_PUSH);
    assign rd_en   = (op == OP_POP);

    always_ff @(posedge clk) begin
        if (rst) begin
            sp    <= '0;
            full  <= 1'b0;
            empty <= 1'b1;
            err   <= 1'b0;
        end else begin
            err <= (op == OP_BAD);
            unique case (op)
                OP_PUSH: begin
                    sp    <= sp_up;
                    empty <= 1'b0;
                    full  <= (sp_up == '0);
                end
                OP_POP: begin
                    sp    <= sp_dn;
                    full  <= 1'b0;
                    empty <= (sp_dn == '0);
                end
                default: begin
                end
            endcase
        end
    end

endmodule

// File: rtl/lifo_store.sv
module lifo_store #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 8,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    input  logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] rd_data
);

    logic [WIDTH-1:0] slot [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (wr_en && (wr_addr == AW'(g))) begin
                slot[g] <= wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= slot[rd_addr];
        end
    end

endmodule

// File: rtl/lifo_regstack.sv
module lifo_regstack #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 8,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_i,
    input  logic             pop_i,
    input  logic [WIDTH-1:0] wdata_i,
    output logic [WIDTH-1:0] rdata_o,
    output logic [AW-1:0]    sp_o,
    output logic             full_o,
    output logic             empty_o,
    output logic             err_o
);

    logic [AW-1:0] wr_addr;
    logic          wr_en;
    logic          rd_en;

    lifo_ptrctl #(.AW(AW)) u_ctl (
        .clk     (clk),
        .rst     (rst),
        .push    (push_i),
        .pop     (pop_i),
        .sp      (sp_o),
        .wr_addr (wr_addr),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .full    (full_o),
        .empty   (empty_o),
        .err     (err_o)
    );

    lifo_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_mem (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wdata_i),
        .rd_en   (rd_en),
        .rd_addr (sp_o),
        .rd_data (rdata_o)
    );

endmodule

// File: rtl/lifo_chk.sv
module lifo_chk #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 8,
    localparam int AW = $clog2(DEPTH)
) (
    input logic             clk,
    input logic             rst,
    input logic             push_i,
    input logic             pop_i,
    input logic [WIDTH-1:0] rdata_o,
    input logic [AW-1:0]    sp_o,
    input logic             full_o,
    input logic             empty_o,
    input logic             err_o
);

    localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);

    // R1: the flags never claim both states at once
    p_flags_excl_r1: assert property (@(posedge clk) disable iff (rst)
        !(full_o && empty_o));

    p_push_step_r2: assert property (@(posedge clk) disable iff (rst)
        (push_i && !pop_i && !full_o) |=> (sp_o == $past(sp_o) + AW'(1)) && !empty_o);

    p_wrap_full_r3: assert property (@(posedge clk) disable iff (rst)
        (push_i && !pop_i && !full_o && sp_o == TOP) |=> full_o && (sp_o == '0));

    p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
        (push_i && !pop_i && full_o) |=> full_o && err_o && $stable(sp_o));

    p_pop_step_r6: assert property (@(posedge clk) disable iff (rst)
        (pop_i && !push_i && !empty_o) |=> (sp_o == $past(sp_o) - AW'(1)) && !full_o);

    p_no_underflow_r7: assert property (@(posedge clk) disable iff (rst)
        (pop_i && !push_i && empty_o) |=> empty_o && err_o && $stable(sp_o) && $stable(rdata_o));

    p_both_noop_r8: assert property (@(posedge clk) disable iff (rst)
        (push_i && pop_i) |=> !err_o && $stable(sp_o) && $stable(rdata_o));

    p_err_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        (!push_i && !pop_i) |=> !err_o);

    p_hold_data_r10: assert property (@(posedge clk) disable iff (rst)
        !pop_i |=> $stable(rdata_o));

endmodule

bind lifo_regstack lifo_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .push_i  (push_i),
    .pop_i   (pop_i),
    .rdata_o (rdata_o),
    .sp_o    (sp_o),
    .full_o  (full_o),
    .empty_o (empty_o),
    .err_o   (err_o)
);

// File: tb/sim_lifo_regstack.sv
`timescale 1ns/1ps
module sim_lifo_regstack;

    localparam int DEPTH = 64;
    localparam int WIDTH = 8;
    localparam int AW    = 6;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             push_i = 1'b0;
    logic             pop_i = 1'b0;
    logic [WIDTH-1:0] wdata_i = '0;
    logic [WIDTH-1:0] rdata_o;
    logic [AW-1:0]    sp_o;
    logic             full_o;
    logic             empty_o;
    logic             err_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    lifo_regstack #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u0 (
        .clk(clk), .rst(rst), .push_i(push_i), .pop_i(pop_i), .wdata_i(wdata_i),
        .rdata_o(rdata_o), .sp_o(sp_o), .full_o(full_o), .empty_o(empty_o), .err_o(err_o)
    );

    // Vector fields: push[26] pop[25] din[24:17] sp[16:11] empty[10] full[9] err[8] dout[7:0]
    localparam logic [26:0] VEC [12] = '{
        {1'b1, 1'b0, 8'hA1, 6'd1, 1'b0, 1'b0, 1'b0, 8'h00},  // R2
        {1'b1, 1'b0, 8'hB2, 6'd2, 1'b0, 1'b0, 1'b0, 8'h00},  // R2
        {1'b1, 1'b0, 8'hC3, 6'd3, 1'b0, 1'b0, 1'b0, 8'h00},  // R2
        {1'b1, 1'b1, 8'h55, 6'd3, 1'b0, 1'b0, 1'b0, 8'h00},  // R8
        {1'b0, 1'b1, 8'h00, 6'd2, 1'b0, 1'b0, 1'b0, 8'hC3},  // R5
        {1'b0, 1'b0, 8'h00, 6'd2, 1'b0, 1'b0, 1'b0, 8'hC3},  // R10
        {1'b1, 1'b0, 8'h44, 6'd3, 1'b0, 1'b0, 1'b0, 8'hC3},  // R10
        {1'b0, 1'b1, 8'h00, 6'd2, 1'b0, 1'b0, 1'b0, 8'h44},  // R5
        {1'b0, 1'b1, 8'h00, 6'd1, 1'b0, 1'b0, 1'b0, 8'hB2},  // R5
        {1'b0, 1'b1, 8'h00, 6'd0, 1'b1, 1'b0, 1'b0, 8'hA1},  // R6
        {1'b0, 1'b1, 8'h00, 6'd0, 1'b1, 1'b0, 1'b1, 8'hA1},  // R7
        {1'b0, 1'b0, 8'h00, 6'd0, 1'b1, 1'b0, 1'b0, 8'hA1}   // R9
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic pu, input logic po, input logic [WIDTH-1:0] d);
        push_i  = pu;
        pop_i   = po;
        wdata_i = d;
        @(posedge clk);
        #1;
        push_i = 1'b0;
        pop_i  = 1'b0;
    endtask

    task automatic expect_state(input string req, input int sp, input bit e,
                                input bit f, input bit er);
        chk(sp_o == AW'(sp), {req, " sp"}, sp_o, sp);
        chk(empty_o == e, {req, " empty"}, empty_o, e);
        chk(full_o == f, {req, " full"}, full_o, f);
        chk(err_o == er, {req, " err"}, err_o, er);
    endtask

    function automatic logic [WIDTH-1:0] pat(input int i);
        return WIDTH'((i * 37 + 11) & 8'hFF);
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        // R1 reset state
        expect_state("R1", 0, 1'b1, 1'b0, 1'b0);
        chk(rdata_o == '0, "R1 rdata", rdata_o, 0);

        for (int i = 0; i < 12; i++) begin
            logic [26:0] v;
            v = VEC[i];
            step(v[26], v[25], v[24:17]);
            expect_state($sformatf("R2-vector%0d", i), int'(v[16:11]), v[10], v[9], v[8]);
            chk(rdata_o == v[7:0], $sformatf("R5 vector%0d rdata", i), rdata_o, v[7:0]);
        end

        // R3: fill the whole stack
        for (int i = 0; i < DEPTH; i++) begin
            step(1'b1, 1'b0, pat(i));
            if (i == DEPTH - 2) expect_state("R3 before wrap", DEPTH - 1, 1'b0, 1'b0, 1'b0);
        end
        expect_state("R3 wrap", 0, 1'b0, 1'b1, 1'b0);

        // R4: overflow attempt with a distinct word
        step(1'b1, 1'b0, 8'hEE);
        expect_state("R4 overflow", 0, 1'b0, 1'b1, 1'b1);
        step(1'b0, 1'b0, '0);
        chk(err_o == 1'b0, "R9 err single cycle", err_o, 0);

        // R5/R6: drain, strict LIFO, nothing from the refused push
        for (int i = DEPTH - 1; i >= 0; i--) begin
            step(1'b0, 1'b1, '0);
            chk(rdata_o == pat(i), $sformatf("R5 drain word %0d", i), rdata_o, pat(i));
            if (i == DEPTH - 1) expect_state("R6 first pop", DEPTH - 1, 1'b0, 1'b0, 1'b0);
        end
        expect_state("R6 drained", 0, 1'b1, 1'b0, 1'b0);

        // R7: underflow keeps the data register
        step(1'b0, 1'b1, '0);
        chk(rdata_o == pat(0), "R7 rdata held", rdata_o, pat(0));
        chk(err_o == 1'b1, "R7 err", err_o, 1);

        // R1: mid-run reset
        step(1'b1, 1'b0, 8'h77);
        step(1'b0, 1'b1, '0);
        rst = 1'b1;
        step(1'b0, 1'b0, '0);
        rst = 1'b0;
        expect_state("R1 mid-run reset", 0, 1'b1, 1'b0, 1'b0);
        chk(rdata_o == '0, "R1 rdata after reset", rdata_o, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule